// File: doc/BRIEF.md
# Amplifier Control Two-Wire Slave

This block is the control port of a stereo amplifier. It is a slave on an I2C bus and runs on a system clock that is much faster than the bus. SCL and SDA pass through synchronisers and are then sampled. START, repeated START and STOP are found from edges of the sampled lines. The block never drives a line high. It pulls SDA low through an output-enable signal, and a board-level pull-up sets the released level.

The device address has seven bits. The upper five bits are a build parameter. The lower two bits come from how a single strap pin is wired: to ground, to the supply, to SCL or to SDA. The block classifies the pin from its own history since each START.

A write carries a register pointer and then any number of data bytes. A read starts with a write of the pointer, followed by a repeated START with the read bit set. Two registers control the amplifier: a mute register with one bit per channel, and a shutdown register. The shutdown register also accepts a soft-reset pattern that returns both registers to their defaults.

Top module: `amp_i2c_ctl`

## Requirements
- R1: After reset, mute_l_o and mute_r_o are 1 and shdn_o is 0.
- R2: The first byte after a START holds a 7-bit address, MSB first, followed by R/W as bit 0 (0 means write, 1 means read). The upper five bits must equal DEV_HI. The lower two bits must equal the strap code: pin tied low gives 00, tied high gives 01, following SCL gives 10, following SDA gives 11. On a match the block pulls SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the rest of the transfer.
- R3: In a write, the byte after the address is the register pointer, and each following byte is data. Every byte is acknowledged, and the pointer increments after each data byte.
- R4: Register 0x01 holds the mute bits: bit 3 is the left channel and bit 4 is the right channel, and 1 means muted. It reads back with all other bits 0.
- R5: In register 0x02, bit 0 drives shdn_o (1 means shut down). It reads back with bits 7..1 at 0.
- R6: A data byte written to 0x02 with bits 7..2 all 1 restores the R1 defaults and ignores its own bit 0.
- R7: A read returns the register at the pointer, MSB first. The pointer increments after each byte. Each master ACK starts the next byte, and unmapped registers read as 0x00.
- R8: A master NACK ends a read. The block then leaves SDA released until the next START.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle at any bit. A data byte that a STOP cuts short is not written.
- R10: A STOP in the same SCL high pulse as a START is ignored. The block stays ready to receive the address.
- R11: Writes to pointers other than 0x01 and 0x02 are acknowledged and discarded.
- R12: A repeated START between two complete write sequences is accepted, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| addr_pin_i | input | 1 | Strap pin that selects the low two address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| mute_l_o | output | 1 | Left channel mute |
| mute_r_o | output | 1 | Right channel mute |
| shdn_o | output | 1 | Amplifier shutdown |

## Verification
The bench builds the block with DEV_HI = 5'b10011 and a two-stage synchroniser. The bus quarter period is eight system clocks, so a synchronised edge arrives well before the master's next transition. The strap wiring is switched between the four options while the simulation runs. This puts every low address pair within reach, along with the rejection of its neighbour, in a single build. Register traffic runs with the strap tied low.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;

    // Register pointers whose layout the amplifier decodes
    localparam logic [7:0] REG_MUTE   = 8'h01;
    localparam logic [7:0] REG_SHDN   = 8'h02;
    localparam int         MUTE_L_BIT = 3;
    localparam int         MUTE_R_BIT = 4;
    localparam int         SHDN_BIT   = 0;
    localparam int         SRST_LSB   = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_REG,
        PH_WDATA,
        PH_TX
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic ml;
        logic mr;
        logic sd;
    } amp_cfg_t;

    localparam amp_cfg_t CFG_DEFAULT = '{ml: 1'b1, mr: 1'b1, sd: 1'b0};

    // Strap classification from history flags gathered since START
    function automatic logic [1:0] strap_code(input logic hi, input logic lo,
                                              input logic f_scl, input logic f_sda);
        if (hi && lo && f_sda)      return 2'b11;
        else if (hi && lo && f_scl) return 2'b10;
        else if (hi && !lo)         return 2'b01;
        else                        return 2'b00;
    endfunction

    function automatic logic [7:0] cfg_readback(input logic [7:0] ptr, input amp_cfg_t c);
        logic [7:0] v;
        v = 8'h00;
        if (ptr == REG_MUTE) begin
            v[MUTE_L_BIT] = c.ml;
            v[MUTE_R_BIT] = c.mr;
        end else if (ptr == REG_SHDN) begin
            v[SHDN_BIT] = c.sd;
        end
        return v;
    endfunction

endpackage

// File: rtl/amp_i2c_sync.sv
module amp_i2c_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[gi]}};
                else     chain <= {chain[STAGES-2:0], d_i[gi]};
            end
            assign q_o[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/amp_i2c_cond.sv
module amp_i2c_cond
    import amp_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev_o
);

    logic scl_p, sda_p;
    logic start_hi;   // a START happened in the current SCL high pulse
    logic raw_start, raw_stop;

    assign raw_start = scl && scl_p && sda_p && !sda;
    assign raw_stop  = scl && scl_p && !sda_p && sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            start_hi <= 1'b0;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
            if (raw_start)          start_hi <= 1'b1;
            else if (scl_p && !scl) start_hi <= 1'b0;
        end
    end

    always_comb begin
        ev_o.start = raw_start;
        ev_o.stop  = raw_stop && !start_hi;
        ev_o.rise  = scl && !scl_p;
        ev_o.fall  = !scl && scl_p;
    end

    AST_EARLY_STOP: assert property (@(posedge clk) disable iff (rst)
        $past(ev_o.start) |-> !ev_o.stop); // R10

endmodule

// File: rtl/amp_i2c_strap.sv
module amp_i2c_strap
    import amp_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       scl,
    input  logic       sda,
    input  logic       pin,
    output logic [1:0] code_o
);

    logic saw_hi, saw_lo, eq_scl, eq_sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            saw_hi <= 1'b0;
            saw_lo <= 1'b0;
            eq_scl <= 1'b1;
            eq_sda <= 1'b1;
        end else if (clear) begin
            saw_hi <= pin;
            saw_lo <= !pin;
            eq_scl <= (pin == scl);
            eq_sda <= (pin == sda);
        end else begin
            saw_hi <= saw_hi | pin;
            saw_lo <= saw_lo | !pin;
            eq_scl <= eq_scl & (pin == scl);
            eq_sda <= eq_sda & (pin == sda);
        end
    end

    assign code_o = strap_code(saw_hi, saw_lo, eq_scl, eq_sda);

    AST_STRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(clear) && !$past(pin)) |-> (code_o != 2'b01)); // R2

endmodule

// File: rtl/amp_i2c_regs.sv
module amp_i2c_regs
    import amp_i2c_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output amp_cfg_t      cfg_o
);

    localparam int SRST_W = 8 - SRST_LSB;

    logic soft_rst;
    assign soft_rst = (&wr_data[7:SRST_LSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= CFG_DEFAULT;
        end else if (wr_en) begin
            if (wr_addr == AW'(REG_MUTE)) begin
                cfg_o.ml <= wr_data[MUTE_L_BIT];
                cfg_o.mr <= wr_data[MUTE_R_BIT];
            end else if (wr_addr == AW'(REG_SHDN)) begin
                if (soft_rst) cfg_o <= CFG_DEFAULT;
                else          cfg_o.sd <= wr_data[SHDN_BIT];
            end
        end
    end

    assign rd_data = cfg_readback(8'(rd_addr), cfg_o);

    AST_RST_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_o.ml && cfg_o.mr && !cfg_o.sd)); // R1

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == AW'(REG_SHDN) && wr_data[7:SRST_LSB] == {SRST_W{1'b1}})
        |=> (cfg_o.ml && cfg_o.mr && !cfg_o.sd)); // R6

    AST_UNMAPPED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != AW'(REG_MUTE) && wr_addr != AW'(REG_SHDN))
        |=> $stable(cfg_o)); // R11

endmodule

// File: rtl/amp_i2c_ctl.sv
module amp_i2c_ctl
    import amp_i2c_pkg::*;
#(
    parameter logic [4:0] DEV_HI      = 5'b10011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_pin_i,
    output logic sda_oe_o,
    output logic mute_l_o,
    output logic mute_r_o,
    output logic shdn_o
);

    localparam int BITS   = 8;
    localparam int CNT_W  = $clog2(BITS + 1);
    localparam int PTR_W  = 8;

    logic [2:0]       sync_q;
    logic             scl_s, sda_s, pin_s;
    bus_ev_t          ev;
    logic [1:0]       strap;
    amp_cfg_t         cfg;

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             in_ack;
    logic             ack_drv;
    logic             rw;
    logic             mack;
    logic [7:0]       sh;
    logic [7:0]       tx;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       rd_data;
    logic             hit;
    logic             byte_end;
    logic             ack_end;
    logic             wr_en;

    amp_i2c_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({addr_pin_i, scl_i, sda_i}),
        .q_o (sync_q)
    );
    assign {pin_s, scl_s, sda_s} = sync_q;

    amp_i2c_cond u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl  (scl_s),
        .sda  (sda_s),
        .ev_o (ev)
    );

    amp_i2c_strap u_strap (
        .clk    (clk),
        .rst    (rst),
        .clear  (ev.start),
        .scl    (scl_s),
        .sda    (sda_s),
        .pin    (pin_s),
        .code_o (strap)
    );

    amp_i2c_regs #(.AW(PTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (sh),
        .rd_addr (ptr),
        .rd_data (rd_data),
        .cfg_o   (cfg)
    );

    assign hit      = (sh[7:1] == {DEV_HI, strap});
    assign byte_end = ev.fall && !in_ack && (cnt == CNT_W'(BITS)) && (phase != PH_IDLE);
    assign ack_end  = ev.fall && in_ack && (phase != PH_IDLE);
    assign wr_en    = byte_end && (phase == PH_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            sh      <= '0;
            tx      <= '1;
            ptr     <= '0;
        end else if (ev.start) begin
            phase   <= PH_ADDR;
            cnt     <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
        end else if (ev.stop) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (ev.rise && !in_ack && cnt < CNT_W'(BITS)) begin
                sh  <= {sh[6:0], sda_s};
                cnt <= cnt + 1'b1;
            end
            if (ev.rise && in_ack && phase == PH_TX) begin
                mack <= !sda_s;
            end
            if (byte_end) begin
                in_ack <= 1'b1;
                unique case (phase)
                    PH_ADDR: begin
                        if (hit) begin
                            ack_drv <= 1'b1;
                            rw      <= sh[0];
                        end else begin
                            phase  <= PH_IDLE;
                            in_ack <= 1'b0;
                            cnt    <= '0;
                        end
                    end
                    PH_REG: begin
                        ack_drv <= 1'b1;
                        ptr     <= sh;
                    end
                    PH_WDATA: begin
                        ack_drv <= 1'b1;
                        ptr     <= ptr + 1'b1;
                    end
                    PH_TX: begin
                        ptr <= ptr + 1'b1;
                    end
                    default: ;
                endcase
            end else if (ack_end) begin
                in_ack  <= 1'b0;
                ack_drv <= 1'b0;
                cnt     <= '0;
                unique case (phase)
                    PH_ADDR: begin
                        if (rw) begin
                            phase <= PH_TX;
                            tx    <= rd_data;
                        end else begin
                            phase <= PH_REG;
                        end
                    end
                    PH_REG:   phase <= PH_WDATA;
                    PH_WDATA: phase <= PH_WDATA;
                    PH_TX: begin
                        if (mack) tx    <= rd_data;
                        else      phase <= PH_IDLE;
                    end
                    default: ;
                endcase
            end else if (ev.fall && phase == PH_TX && !in_ack && cnt != '0) begin
                tx <= {tx[6:0], 1'b1};
            end
        end
    end

    assign sda_oe_o = ack_drv || (phase == PH_TX && !in_ack && !tx[7]);
    assign mute_l_o = cfg.ml;
    assign mute_r_o = cfg.mr;
    assign shdn_o   = cfg.sd;

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == PH_IDLE && !sda_oe_o)); // R9

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_s); // R2

    AST_ADDR_MISS: assert property (@(posedge clk) disable iff (rst)
        (byte_end && phase == PH_ADDR && !hit) |=> (phase == PH_IDLE && !sda_oe_o)); // R2

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ack_end && phase == PH_TX && !mack) |=> !sda_oe_o); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(BITS)); // R3

endmodule

// File: tb/amp_i2c_ctl_test.sv
module amp_i2c_ctl_test;

    localparam int         Q  = 8;
    localparam logic [4:0] HI = 5'b10011;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap_sel = 2'd0;
    logic       pin;
    logic       sda_bus;
    logic       sda_oe, ml, mr, sd;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always_comb begin
        case (strap_sel)
            2'd0:    pin = 1'b0;
            2'd1:    pin = 1'b1;
            2'd2:    pin = m_scl;
            default: pin = sda_bus;
        endcase
    end

    always #4 clk = ~clk;

    amp_i2c_ctl #(.DEV_HI(HI), .SYNC_STAGES(2)) uut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .addr_pin_i (pin),
        .sda_oe_o   (sda_oe),
        .mute_l_o   (ml),
        .mute_r_o   (mr),
        .shdn_o     (sd)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic e_ml, input logic e_mr, input logic e_sd);
        chk(req, "outputs {ml,mr,sd}", {5'b0, ml, mr, sd}, {5'b0, e_ml, e_mr, e_sd});
    endtask

    task automatic qwait;
        repeat (Q) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {HI, strap_sel, rd};
    endfunction

    task automatic wbit(input logic b, output logic s);
        m_sda = b;
        qwait();
        m_scl = 1'b1;
        qwait();
        s = sda_bus;
        qwait();
        m_scl = 1'b0;
        qwait();
    endtask

    task automatic bstart;
        m_sda = 1'b1;
        m_scl = 1'b1;
        qwait(); qwait();
        m_sda = 1'b0;
        qwait(); qwait();
        m_scl = 1'b0;
        qwait();
    endtask

    task automatic brestart;
        m_sda = 1'b1;
        qwait();
        m_scl = 1'b1;
        qwait(); qwait();
        m_sda = 1'b0;
        qwait(); qwait();
        m_scl = 1'b0;
        qwait();
    endtask

    task automatic bstop;
        m_sda = 1'b0;
        qwait();
        m_scl = 1'b1;
        qwait(); qwait();
        m_sda = 1'b1;
        qwait(); qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) wbit(b[i], s);
        wbit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            wbit(1'b1, s);
            b[i] = s;
        end
        wbit(!give_ack, s);
    endtask

    task automatic reg_write(input logic [7:0] ra, input logic [7:0] d);
        logic a0, a1, a2;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(ra, a1);
        send_byte(d, a2);
        bstop();
        chk("R3", "write acks", {5'b0, a0, a1, a2}, 8'h07);
    endtask

    task automatic reg_read(input logic [7:0] ra, output logic [7:0] d);
        logic a0, a1, a2;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(ra, a1);
        brestart();
        send_byte(dev(1'b1), a2);
        recv_byte(1'b0, d);
        bstop();
        chk("R7", "read acks", {5'b0, a0, a1, a2}, 8'h07);
    endtask

    task automatic t_reset;
        chk_out("R1", 1'b1, 1'b1, 1'b0);
        chk("R1", "sda released", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_mute;
        logic [7:0] d;
        reg_write(8'h01, 8'h08);
        chk_out("R4", 1'b1, 1'b0, 1'b0);
        reg_read(8'h01, d);
        chk("R4", "mute readback", d, 8'h08);
        reg_write(8'h01, 8'hFF);
        chk_out("R4", 1'b1, 1'b1, 1'b0);
        reg_read(8'h01, d);
        chk("R4", "mute other bits zero", d, 8'h18);
        reg_write(8'h01, 8'h00);
        chk_out("R4", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_shdn;
        logic [7:0] d;
        reg_write(8'h02, 8'hFF & 8'h03);
        chk_out("R5", 1'b0, 1'b0, 1'b1);
        reg_read(8'h02, d);
        chk("R5", "shdn readback", d, 8'h01);
    endtask

    task automatic t_soft;
        logic [7:0] d;
        reg_write(8'h02, 8'hFC);
        chk_out("R6", 1'b1, 1'b1, 1'b0);
        reg_read(8'h02, d);
        chk("R6", "shdn after soft reset", d, 8'h00);
        reg_read(8'h01, d);
        chk("R6", "mute after soft reset", d, 8'h18);
    endtask

    task automatic t_burst_write;
        logic a0, a1, a2, a3;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h01, a1);
        send_byte(8'h10, a2);
        send_byte(8'h01, a3);
        bstop();
        chk("R3", "burst acks", {4'b0, a0, a1, a2, a3}, 8'h0F);
        chk_out("R3", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_burst_read;
        logic a0, a1, a2;
        logic [7:0] d0, d1;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h01, a1);
        brestart();
        send_byte(dev(1'b1), a2);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bstop();
        chk("R7", "burst read acks", {5'b0, a0, a1, a2}, 8'h07);
        chk("R7", "first byte", d0, 8'h10);
        chk("R7", "second byte", d1, 8'h01);
        reg_read(8'h03, d0);
        chk("R7", "unmapped reads zero", d0, 8'h00);
    endtask

    task automatic t_restart_write;
        logic a0, a1, a2, a3, a4, a5;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h01, a1);
        send_byte(8'h08, a2);
        brestart();
        send_byte(dev(1'b0), a3);
        send_byte(8'h02, a4);
        send_byte(8'h00, a5);
        bstop();
        chk("R12", "acks", {2'b0, a0, a1, a2, a3, a4, a5}, 8'h3F);
        chk_out("R12", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        logic a0, a1, a2;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h05, a1);
        send_byte(8'hFF, a2);
        bstop();
        chk("R11", "acks", {5'b0, a0, a1, a2}, 8'h07);
        chk_out("R11", 1'b1, 1'b0, 1'b0);
        reg_read(8'h05, d);
        chk("R11", "unmapped keeps zero", d, 8'h00);
    endtask

    task automatic t_stop_abort;
        logic [7:0] d;
        logic a0, a1, s;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h01, a1);
        for (int i = 0; i < 4; i++) wbit(1'b0, s);
        bstop();
        chk("R9", "acks before stop", {6'b0, a0, a1}, 8'h03);
        chk_out("R9", 1'b1, 1'b0, 1'b0);
        reg_read(8'h01, d);
        chk("R9", "mute kept after aborted byte", d, 8'h08);
    endtask

    task automatic t_nack;
        logic [7:0] d, extra;
        logic a0, a1, a2;
        bstart();
        send_byte(dev(1'b0), a0);
        send_byte(8'h01, a1);
        brestart();
        send_byte(dev(1'b1), a2);
        recv_byte(1'b0, d);
        recv_byte(1'b0, extra);
        bstop();
        chk("R8", "data before nack", d, 8'h08);
        chk("R8", "released after nack", extra, 8'hFF);
    endtask

    task automatic t_early_stop;
        logic a0;
        m_scl = 1'b1;
        m_sda = 1'b1;
        qwait(); qwait();
        m_sda = 1'b0;
        qwait(); qwait();
        m_sda = 1'b1;
        qwait();
        m_scl = 1'b0;
        qwait();
        send_byte(dev(1'b0), a0);
        bstop();
        chk("R10", "address acked after early stop", {7'b0, a0}, 8'h01);
    endtask

    task automatic t_strap;
        logic a0, a1;
        for (int c = 0; c < 4; c++) begin
            strap_sel = 2'(c);
            qwait();
            bstart();
            send_byte({HI, 2'(c), 1'b0}, a0);
            bstop();
            bstart();
            send_byte({HI, 2'(c) ^ 2'b01, 1'b0}, a1);
            bstop();
            chk("R2", "strap match ack", {7'b0, a0}, 8'h01);
            chk("R2", "strap neighbour nack", {7'b0, a1}, 8'h00);
        end
        strap_sel = 2'd0;
        qwait();
        bstart();
        send_byte({~HI, 2'b00, 1'b0}, a0);
        bstop();
        chk("R2", "upper bits mismatch nack", {7'b0, a0}, 8'h00);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        qwait();
        t_reset();
        t_mute();
        t_shdn();
        t_soft();
        t_burst_write();
        t_burst_read();
        t_restart_write();
        t_unmapped();
        t_stop_abort();
        t_nack();
        t_early_stop();
        t_strap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule